// File: doc/BRIEF.md
# Flag Register with Branch Select

This block stores the four condition flags that an ALU produces (carry, zero, overflow, negative). It uses them to decide where the next instruction address of a small microprogrammed processor comes from. A load strobe captures the ALU flag outputs on a clock edge. A 2-bit field of the microcode word then picks one stored flag as the branch condition, and that condition is available combinationally.

The address bus has three possible drivers: the incremented program counter, a branch target, and an auxiliary source. They are modelled as one-hot enables plus a multiplexed address output rather than as tri-state buffers. When the selected flag is clear, the program counter path is used. When the flag is set, a microcode source bit chooses between the branch target and the auxiliary source. All enables stay low until the timing strobe opens the window in which the bus may change, so that at most one driver is ever enabled.

Top module: `flag_branch_sel`

## Requirements
- R1: While `rst_ni` is low, and at once when it falls (asynchronously), the stored flags are 0, so `flags_o` reads 4'b0000.
- R2: On a rising clock edge with `flag_we_i` high, `flags_o` takes the value of `alu_flags_i`. The bit layout is bit 0 = carry, bit 1 = zero, bit 2 = overflow, bit 3 = negative.
- R3: On a rising clock edge with `flag_we_i` low, `flags_o` keeps its value whatever `alu_flags_i` carries.
- R4: `cond_o` is combinationally the stored flag picked by `cond_sel_i`, with the encoding 00 = carry, 01 = zero, 10 = overflow, 11 = negative.
- R5: With `strobe_i` low, `src_en_o` is 3'b000 and `addr_o` is 0.
- R6: With `strobe_i` high and `cond_o` low, `src_en_o` is 3'b001 (bit 0 = program counter path) and `addr_o` equals `pc_next_i`.
- R7: With `strobe_i` high, `cond_o` high and `alt_sel_i` low, `src_en_o` is 3'b010 (bit 1 = branch target) and `addr_o` equals `br_tgt_i`.
- R8: With `strobe_i` high, `cond_o` high and `alt_sel_i` high, `src_en_o` is 3'b100 (bit 2 = auxiliary source) and `addr_o` equals `aux_addr_i`.
- R9: `src_en_o` is never anything other than zero or one-hot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| flag_we_i | input | 1 | Flag load strobe |
| alu_flags_i | input | 4 | ALU flags {N,V,Z,C} |
| cond_sel_i | input | 2 | Branch condition select from microcode |
| alt_sel_i | input | 1 | Taken-branch source: 0 branch target, 1 auxiliary |
| strobe_i | input | 1 | Timing window for address bus change |
| pc_next_i | input | AW | Incremented program counter |
| br_tgt_i | input | AW | Branch target address |
| aux_addr_i | input | AW | Auxiliary address source |
| flags_o | output | 4 | Stored flags {N,V,Z,C} |
| cond_o | output | 1 | Selected branch condition |
| src_en_o | output | 3 | One-hot source enables {aux,branch,pc} |
| addr_o | output | AW | Selected next address |

## Verification
All sixteen stored flag patterns are combined with every select value, both source choices and both strobe levels. This separates a wrong select decode from a wrong bit order in the register, because each select value lands on a different flag. It also separates a strobe leak from a wrong source choice, and a branch target from the auxiliary path. Loads with the write enable low, alongside changing ALU inputs, show whether the register ignores them. A reset asserted in the middle of a run shows whether clearing happens without a clock edge.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  localparam int NUM_FLAGS = 4;
  localparam int SEL_W     = $clog2(NUM_FLAGS);
  localparam int NUM_SRC   = 3;

  typedef enum logic [SEL_W-1:0] {
    FLAG_C = 2'd0,
    FLAG_Z = 2'd1,
    FLAG_V = 2'd2,
    FLAG_N = 2'd3
  } flag_idx_e;

  localparam int SRC_PC  = 0;
  localparam int SRC_BR  = 1;
  localparam int SRC_AUX = 2;
endpackage

// File: rtl/fbs_flag_reg.sv
module fbs_flag_reg
  import fbs_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic [NUM_FLAGS-1:0] d_i,
  output logic [NUM_FLAGS-1:0] q_o
);
  logic [NUM_FLAGS-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_r <= '0;
    else if (we_i) q_r <= d_i;
  end

  assign q_o = q_r;
endmodule

// File: rtl/fbs_cond_mux.sv
module fbs_cond_mux
  import fbs_pkg::*;
(
  input  logic [NUM_FLAGS-1:0] flags_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 cond_o
);
  logic [NUM_FLAGS-1:0] dec;
  logic [NUM_FLAGS-1:0] path;

  // decode select, enable a single bit path
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_path
    assign dec[i]  = (sel_i == SEL_W'(i));
    assign path[i] = dec[i] & flags_i[i];
  end

  assign cond_o = |path;
endmodule

// File: rtl/fbs_src_arb.sv
module fbs_src_arb
  import fbs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                        cond_i,
  input  logic                        alt_sel_i,
  input  logic                        strobe_i,
  input  logic [NUM_SRC-1:0][AW-1:0]  src_addr_i,
  output logic [NUM_SRC-1:0]          en_o,
  output logic [AW-1:0]               addr_o
);
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0][AW-1:0] gated;

  assign req[SRC_PC]  = ~cond_i;
  assign req[SRC_BR]  =  cond_i & ~alt_sel_i;
  assign req[SRC_AUX] =  cond_i &  alt_sel_i;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign en_o[i]  = strobe_i & req[i];
    assign gated[i] = {AW{en_o[i]}} & src_addr_i[i];
  end

  always_comb begin
    addr_o = '0;
    for (int i = 0; i < NUM_SRC; i++) addr_o = addr_o | gated[i];
  end
endmodule

// File: rtl/flag_branch_sel.sv
module flag_branch_sel
  import fbs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 flag_we_i,
  input  logic [NUM_FLAGS-1:0] alu_flags_i,
  input  logic [SEL_W-1:0]     cond_sel_i,
  input  logic                 alt_sel_i,
  input  logic                 strobe_i,
  input  logic [AW-1:0]        pc_next_i,
  input  logic [AW-1:0]        br_tgt_i,
  input  logic [AW-1:0]        aux_addr_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 cond_o,
  output logic [NUM_SRC-1:0]   src_en_o,
  output logic [AW-1:0]        addr_o
);
  logic [NUM_FLAGS-1:0] flags_q;
  logic                 cond;
  logic [NUM_SRC-1:0][AW-1:0] src_addr;

  assign src_addr[SRC_PC]  = pc_next_i;
  assign src_addr[SRC_BR]  = br_tgt_i;
  assign src_addr[SRC_AUX] = aux_addr_i;

  fbs_flag_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (flag_we_i),
    .d_i   (alu_flags_i),
    .q_o   (flags_q)
  );

  fbs_cond_mux u_mux (
    .flags_i(flags_q),
    .sel_i  (cond_sel_i),
    .cond_o (cond)
  );

  fbs_src_arb #(.AW(AW)) u_arb (
    .cond_i    (cond),
    .alt_sel_i (alt_sel_i),
    .strobe_i  (strobe_i),
    .src_addr_i(src_addr),
    .en_o      (src_en_o),
    .addr_o    (addr_o)
  );

  assign flags_o = flags_q;
  assign cond_o  = cond;
endmodule

// File: rtl/fbs_checker.sv
module fbs_checker
  import fbs_pkg::*;
#(
  parameter int AW = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 flag_we_i,
  input logic [NUM_FLAGS-1:0] alu_flags_i,
  input logic [SEL_W-1:0]     cond_sel_i,
  input logic                 alt_sel_i,
  input logic                 strobe_i,
  input logic [AW-1:0]        pc_next_i,
  input logic [AW-1:0]        br_tgt_i,
  input logic [AW-1:0]        aux_addr_i,
  input logic [NUM_FLAGS-1:0] flags_o,
  input logic                 cond_o,
  input logic [NUM_SRC-1:0]   src_en_o,
  input logic [AW-1:0]        addr_o
);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_we_i |=> flags_o == $past(alu_flags_i));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_we_i |=> $stable(flags_o));

  assert_cond_sel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_o == flags_o[cond_sel_i]);

  assert_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |-> (src_en_o == '0 && addr_o == '0));

  assert_pc_path_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !cond_o) |-> (src_en_o == 3'b001 && addr_o == pc_next_i));

  assert_br_path_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cond_o && !alt_sel_i) |-> (src_en_o == 3'b010 && addr_o == br_tgt_i));

  assert_aux_path_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && cond_o && alt_sel_i) |-> (src_en_o == 3'b100 && addr_o == aux_addr_i));

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(src_en_o));
endmodule

bind flag_branch_sel fbs_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .flag_we_i  (flag_we_i),
  .alu_flags_i(alu_flags_i),
  .cond_sel_i (cond_sel_i),
  .alt_sel_i  (alt_sel_i),
  .strobe_i   (strobe_i),
  .pc_next_i  (pc_next_i),
  .br_tgt_i   (br_tgt_i),
  .aux_addr_i (aux_addr_i),
  .flags_o    (flags_o),
  .cond_o     (cond_o),
  .src_en_o   (src_en_o),
  .addr_o     (addr_o)
);

// File: tb/sim_flag_branch_sel.sv
module sim_flag_branch_sel;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          flag_we_i = 1'b0;
  logic [3:0]    alu_flags_i = '0;
  logic [1:0]    cond_sel_i = '0;
  logic          alt_sel_i = 1'b0;
  logic          strobe_i = 1'b0;
  logic [AW-1:0] pc_next_i = '0;
  logic [AW-1:0] br_tgt_i = '0;
  logic [AW-1:0] aux_addr_i = '0;
  logic [3:0]    flags_o;
  logic          cond_o;
  logic [2:0]    src_en_o;
  logic [AW-1:0] addr_o;

  always #5 clk_i = ~clk_i;

  flag_branch_sel #(.AW(AW)) u0 (.*);

  typedef struct {
    string         ftag;
    string         ptag;
    logic [3:0]    flags;
    logic          cond;
    logic [2:0]    en;
    logic [AW-1:0] addr;
  } exp_t;

  exp_t       sb[$];
  int         n_chk = 0;
  int         n_fail = 0;
  logic [3:0] model = '0;
  bit         done = 0;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: apply one probe and push the expected result
  task automatic probe(logic [1:0] sel, logic alt, logic stb, logic [AW-1:0] seed, string ftag);
    exp_t e;
    logic c;
    @(negedge clk_i);
    cond_sel_i = sel;
    alt_sel_i  = alt;
    strobe_i   = stb;
    pc_next_i  = 16'h1000 ^ seed;
    br_tgt_i   = 16'h2400 ^ seed;
    aux_addr_i = 16'h3810 ^ seed;
    c = model[sel];
    e.ftag  = ftag;
    e.flags = model;
    e.cond  = c;
    if (!stb) begin
      e.ptag = "R5"; e.en = 3'b000; e.addr = '0;
    end else if (!c) begin
      e.ptag = "R6"; e.en = 3'b001; e.addr = pc_next_i;
    end else if (!alt) begin
      e.ptag = "R7"; e.en = 3'b010; e.addr = br_tgt_i;
    end else begin
      e.ptag = "R8"; e.en = 3'b100; e.addr = aux_addr_i;
    end
    sb.push_back(e);
  endtask

  task automatic load_flags(logic [3:0] f);
    @(negedge clk_i);
    flag_we_i   = 1'b1;
    alu_flags_i = f;
    @(negedge clk_i);
    flag_we_i   = 1'b0;
    model       = f;
  endtask

  // monitor: pop and compare two time units after the falling edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        chk(flags_o == e.flags, e.ftag, "flags_o", 32'(flags_o), 32'(e.flags));
        chk(cond_o == e.cond, "R4", "cond_o", 32'(cond_o), 32'(e.cond));
        chk(src_en_o == e.en, e.ptag, "src_en_o", 32'(src_en_o), 32'(e.en));
        chk(addr_o == e.addr, e.ptag, "addr_o", 32'(addr_o), 32'(e.addr));
        chk($countones(src_en_o) <= 1, "R9", "src_en_o onehot0", 32'(src_en_o), 32'(e.en));
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state, even with load requested
    alu_flags_i = 4'hF;
    flag_we_i   = 1'b1;
    probe(2'd1, 1'b0, 1'b1, 16'h0001, "R1");
    @(negedge clk_i);
    flag_we_i = 1'b0;
    rst_ni    = 1'b1;

    // R2/R4..R8: every flag pattern, select, source choice and strobe level
    for (int f = 0; f < 16; f++) begin
      load_flags(4'(f));
      for (int s = 0; s < 4; s++)
        for (int a = 0; a < 2; a++)
          for (int t = 0; t < 2; t++)
            probe(2'(s), a[0], t[0], 16'(f * 64 + s * 8 + a * 2 + t), "R2");
    end

    // R3: write enable low ignores changing ALU flags
    load_flags(4'b0101);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk_i);
      alu_flags_i = 4'(~k);
      probe(2'(k), 1'b1, 1'b1, 16'(k + 7), "R3");
    end

    // R1: asynchronous reset mid-run clears flags without a clock edge
    load_flags(4'b1111);
    @(negedge clk_i);
    #1 rst_ni = 1'b0;
    model = '0;
    #1;
    chk(flags_o == 4'b0000, "R1", "flags_o async clear", 32'(flags_o), 32'h0);
    probe(2'd3, 1'b0, 1'b1, 16'h00AA, "R1");
    @(negedge clk_i);
    rst_ni = 1'b1;
    probe(2'd0, 1'b1, 1'b1, 16'h0055, "R1");

    repeat (3) @(negedge clk_i);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule